// File: doc/BRIEF.md
# Flash Page Read Sequencer

This block turns a one-line host read request into the pin sequence that a parallel NAND-style flash device needs to return a byte. The host presents a 23-bit address and raises a request for at least one clock. The sequencer then drives one read-command cycle, then three address cycles, and then waits for the device to report busy and, after that, ready. It finishes with a read strobe. It raises a one-cycle data-ready pulse while the device drives valid data on its pins. The host is expected to capture the data itself in that cycle.

A sequential-access flag skips the command and address phases when the host knows that the device already points at the wanted data. The read strobe comes straight from a flip-flop, so the device never sees a glitch on it. The device's ready/busy line is asynchronous and is brought into the clock domain through a two-stage synchronizer.

Top module: `flash_rd_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows the idle pin state: `fl_cle`=0, `fl_ale`=0, `fl_we_n`=1, `fl_re_n`=1, `fl_io`=0x00 and `host_data_ready`=0.
- R2: Suppose `host_rd_req`=1 and `host_seq`=0 are sampled while idle. The four following cycles form the command phase, and `fl_io`=0x00 in all four. `fl_cle`=1 in cycles 1 to 3 and 0 in cycle 4. `fl_we_n`=0 in cycles 1 and 2, and 1 in cycles 3 and 4.
- R3: Cycles 5 to 13 form three address groups of three cycles each, with `fl_ale`=1 and `fl_cle`=0. In each group `fl_we_n` is 0 for the first two cycles and 1 for the third. The groups carry address bits [7:0], then [15:8], then {1'b0, [22:16]} on `fl_io`. The address is the one presented when the request was accepted, and later changes of `host_addr` have no effect.
- R4: Cycle 14 drives all strobes inactive and `fl_io`=0x00. After that, the block waits, with `host_data_ready`=0 and `fl_re_n`=1, until `fl_ready` has been seen low and then high again. It waits for as long as the line stays unchanged.
- R5: `fl_ready` (1 = ready, 0 = busy) reaches the state logic through two flip-flops. After a synchronized low, a rise of `fl_ready` ahead of edge e1 gives `host_data_ready`=1 in the cycle that starts at edge e1+4.
- R6: `fl_re_n` is registered and resets high. It falls one cycle after the read-low step begins, stays low through the wait step and the data-ready step, and returns high in the cycle after data-ready.
- R7: `host_data_ready` is high for exactly one cycle per read, and only while `fl_re_n` is low.
- R8: Suppose `host_rd_req`=1 and `host_seq`=1 are sampled while idle. The read-low step starts at the next edge, with no command or address activity. `fl_re_n` is low in cycles 2 and 3, and `host_data_ready`=1 in cycle 3.
- R9: `host_rd_req` and `host_seq` are ignored outside the idle state. With the request low, the block stays idle.
- R10: A reset during a transaction returns the block to idle, with `fl_re_n` high, from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_rd_req | input | 1 | Read request, sampled while idle |
| host_seq | input | 1 | Sequential-access flag: skip the command and address phases |
| host_addr | input | 23 | Byte address, captured when the request is accepted |
| host_data_ready | output | 1 | High for one cycle while the flash data is valid |
| fl_io | output | 8 | Command or address byte toward the flash |
| fl_ale | output | 1 | Address latch enable |
| fl_cle | output | 1 | Command latch enable |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_re_n | output | 1 | Read strobe, active low, registered |
| fl_ready | input | 1 | Device ready (1) / busy (0), asynchronous |

## Verification
The command and address pins follow the state register with no extra delay. After the request edge, each of the 14 steps is therefore compared at the falling edge that ends that step's cycle. The ready/busy path is due four edges after its first flip-flop samples a rise. The bench drives that rise at a falling edge and counts edges to the data-ready cycle. It checks the strobe level and data-ready at each edge on the way, so one cycle of drift fails a check. The sequential-access path is checked the same way, counting from the request edge. `fl_re_n` lags its state by one register, and the bench samples it one cycle later than the state step that sets it.

// File: rtl/flash_rd_pkg.sv
// Shared types and constants of the flash read sequencer.
// Assumes: state values are dense from 0; any other code is unused.
package flash_rd_pkg;

    localparam int unsigned STATE_W = 5;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE       = 5'd0,
        ST_CMD_GO     = 5'd1,
        ST_CMD_HOLD   = 5'd2,
        ST_CMD_WEH    = 5'd3,
        ST_CMD_END    = 5'd4,
        ST_AD0_GO     = 5'd5,
        ST_AD0_HOLD   = 5'd6,
        ST_AD0_WEH    = 5'd7,
        ST_AD1_GO     = 5'd8,
        ST_AD1_HOLD   = 5'd9,
        ST_AD1_WEH    = 5'd10,
        ST_AD2_GO     = 5'd11,
        ST_AD2_HOLD   = 5'd12,
        ST_AD2_WEH    = 5'd13,
        ST_AD_END     = 5'd14,
        ST_BUSY_WAIT  = 5'd15,
        ST_READY_WAIT = 5'd16,
        ST_RD_LOW     = 5'd17,
        ST_RD_HOLD    = 5'd18,
        ST_RD_HIGH    = 5'd19
    } seq_state_t;

    localparam int unsigned ADDR_GROUPS = 3;

endpackage

// File: rtl/frs_sync.sv
// Multi-stage synchronizer for one asynchronous level.
// Assumes: input is a slow level; output settles STAGES edges after a change.
module frs_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the sampled level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/frs_ctrl.sv
// State register and transition logic of the read sequencer.
// Assumes: dev_ready is already synchronized; unused codes fall back to idle.
module frs_ctrl
    import flash_rd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_req,
    input  logic       seq_req,
    input  logic       dev_ready,
    output seq_state_t state,
    output logic       accept
);
    seq_state_t state_q;
    seq_state_t state_d;

    // Sample request only in idle.
    assign accept = (state_q == ST_IDLE) && rd_req;

    // Next-state selection for each step of the sequence.
    always_comb begin
        state_d = ST_IDLE;
        case (state_q)
            ST_IDLE: begin
                if (rd_req) begin
                    state_d = seq_req ? ST_RD_LOW : ST_CMD_GO;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_CMD_GO:     state_d = ST_CMD_HOLD;
            ST_CMD_HOLD:   state_d = ST_CMD_WEH;
            ST_CMD_WEH:    state_d = ST_CMD_END;
            ST_CMD_END:    state_d = ST_AD0_GO;
            ST_AD0_GO:     state_d = ST_AD0_HOLD;
            ST_AD0_HOLD:   state_d = ST_AD0_WEH;
            ST_AD0_WEH:    state_d = ST_AD1_GO;
            ST_AD1_GO:     state_d = ST_AD1_HOLD;
            ST_AD1_HOLD:   state_d = ST_AD1_WEH;
            ST_AD1_WEH:    state_d = ST_AD2_GO;
            ST_AD2_GO:     state_d = ST_AD2_HOLD;
            ST_AD2_HOLD:   state_d = ST_AD2_WEH;
            ST_AD2_WEH:    state_d = ST_AD_END;
            ST_AD_END:     state_d = ST_BUSY_WAIT;
            ST_BUSY_WAIT:  state_d = dev_ready ? ST_BUSY_WAIT : ST_READY_WAIT;
            ST_READY_WAIT: state_d = dev_ready ? ST_RD_LOW : ST_READY_WAIT;
            ST_RD_LOW:     state_d = ST_RD_HOLD;
            ST_RD_HOLD:    state_d = ST_RD_HIGH;
            ST_RD_HIGH:    state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/frs_pins.sv
// Pin decoder: command/address bus, latch enables, write strobe, registered read strobe.
// Assumes: ADDR_W < ADDR_GROUPS*IO_W; the upper address byte is zero-padded.
module frs_pins
    import flash_rd_pkg::*;
#(
    parameter int unsigned ADDR_W   = 23,
    parameter int unsigned IO_W     = 8,
    parameter logic [7:0]  READ_CMD = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [IO_W-1:0]   io,
    output logic              ale,
    output logic              cle,
    output logic              we_n,
    output logic              re_n,
    output logic              data_ready
);
    localparam int unsigned PAD_W = ADDR_GROUPS * IO_W;

    logic [ADDR_W-1:0] addr_q;
    logic [PAD_W-1:0]  addr_pad;
    logic [IO_W-1:0]   addr_byte [ADDR_GROUPS];
    logic [IO_W-1:0]   cmd_byte;

    // Hold the address captured at request acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (accept) begin
            addr_q <= addr_in;
        end
    end

    assign addr_pad = {{(PAD_W-ADDR_W){1'b0}}, addr_q};
    assign cmd_byte = IO_W'(READ_CMD);

    for (genvar g = 0; g < ADDR_GROUPS; g++) begin : g_byte
        assign addr_byte[g] = addr_pad[g*IO_W +: IO_W];
    end

    // Decode latch enables, write strobe and bus value from the state.
    always_comb begin
        cle  = 1'b0;
        ale  = 1'b0;
        we_n = 1'b1;
        io   = '0;
        case (state)
            ST_CMD_GO, ST_CMD_HOLD: begin
                cle  = 1'b1;
                we_n = 1'b0;
                io   = cmd_byte;
            end
            ST_CMD_WEH: begin
                cle = 1'b1;
                io  = cmd_byte;
            end
            ST_CMD_END: io = cmd_byte;
            ST_AD0_GO, ST_AD0_HOLD: begin
                ale  = 1'b1;
                we_n = 1'b0;
                io   = addr_byte[0];
            end
            ST_AD0_WEH: begin
                ale = 1'b1;
                io  = addr_byte[0];
            end
            ST_AD1_GO, ST_AD1_HOLD: begin
                ale  = 1'b1;
                we_n = 1'b0;
                io   = addr_byte[1];
            end
            ST_AD1_WEH: begin
                ale = 1'b1;
                io  = addr_byte[1];
            end
            ST_AD2_GO, ST_AD2_HOLD: begin
                ale  = 1'b1;
                we_n = 1'b0;
                io   = addr_byte[2];
            end
            ST_AD2_WEH: begin
                ale = 1'b1;
                io  = addr_byte[2];
            end
            default: begin
                cle  = 1'b0;
                ale  = 1'b0;
                we_n = 1'b1;
                io   = '0;
            end
        endcase
    end

    // Registered read strobe: clear at read-low, set at read-high, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            re_n <= 1'b1;
        end else if (state == ST_RD_LOW) begin
            re_n <= 1'b0;
        end else if (state == ST_RD_HIGH) begin
            re_n <= 1'b1;
        end
    end

    assign data_ready = (state == ST_RD_HIGH);
endmodule

// File: rtl/flash_rd_seq.sv
// Top of the flash read sequencer: synchronizer, controller and pin decoder.
// Assumes: host holds request until accepted; fl_ready is asynchronous.
module flash_rd_seq
    import flash_rd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 23,
    parameter int unsigned IO_W        = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rd_req,
    input  logic              host_seq,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              host_data_ready,
    output logic [IO_W-1:0]   fl_io,
    output logic              fl_ale,
    output logic              fl_cle,
    output logic              fl_we_n,
    output logic              fl_re_n,
    input  logic              fl_ready
);
    seq_state_t state;
    logic       accept;
    logic       ready_sync;

    frs_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (fl_ready),
        .sync_out (ready_sync)
    );

    frs_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (host_rd_req),
        .seq_req   (host_seq),
        .dev_ready (ready_sync),
        .state     (state),
        .accept    (accept)
    );

    frs_pins #(.ADDR_W(ADDR_W), .IO_W(IO_W)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .accept     (accept),
        .addr_in    (host_addr),
        .io         (fl_io),
        .ale        (fl_ale),
        .cle        (fl_cle),
        .we_n       (fl_we_n),
        .re_n       (fl_re_n),
        .data_ready (host_data_ready)
    );
endmodule

// File: rtl/flash_rd_seq_chk.sv
// Port-level property checker for flash_rd_seq, attached by bind.
module flash_rd_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic host_data_ready,
    input logic fl_ale,
    input logic fl_cle,
    input logic fl_we_n,
    input logic fl_re_n
);
    // R1: reset forces idle pins.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (fl_re_n && !fl_cle && !fl_ale && fl_we_n && !host_data_ready));

    // R2, R3: write strobe only inside exactly one of the latch phases.
    p_strobe_in_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> (fl_cle ^ fl_ale));

    p_latch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_cle && fl_ale));

    // R6: strobe fall leads to data-ready next cycle; release after it.
    p_re_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_re_n) |=> host_data_ready);

    p_re_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_data_ready |=> fl_re_n);

    // R7: data-ready only under a low strobe, one cycle wide.
    p_ready_under_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_data_ready |-> !fl_re_n);

    p_ready_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_data_ready |=> !host_data_ready);
endmodule

bind flash_rd_seq flash_rd_seq_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .host_data_ready (host_data_ready),
    .fl_ale          (fl_ale),
    .fl_cle          (fl_cle),
    .fl_we_n         (fl_we_n),
    .fl_re_n         (fl_re_n)
);

// File: tb/flash_rd_seq_tb.sv
// Self-checking bench for flash_rd_seq: vector table loop, then directed tests.
module flash_rd_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 5;

    typedef struct packed {
        logic [22:0] addr;
        logic [7:0]  pre_busy;
        logic [7:0]  busy_len;
    } vec_t;

    localparam vec_t VECS [N_VEC] = '{
        '{23'h000000, 8'd0,  8'd3},
        '{23'h7FFFFF, 8'd2,  8'd4},
        '{23'h2A55C3, 8'd20, 8'd3},
        '{23'h400001, 8'd1,  8'd30},
        '{23'h13579B, 8'd5,  8'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_rd_req = 1'b0;
    logic        host_seq = 1'b0;
    logic [22:0] host_addr = '0;
    logic        host_data_ready;
    logic [7:0]  fl_io;
    logic        fl_ale, fl_cle, fl_we_n, fl_re_n;
    logic        fl_ready = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_rd_seq u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .host_rd_req     (host_rd_req),
        .host_seq        (host_seq),
        .host_addr       (host_addr),
        .host_data_ready (host_data_ready),
        .fl_io           (fl_io),
        .fl_ale          (fl_ale),
        .fl_cle          (fl_cle),
        .fl_we_n         (fl_we_n),
        .fl_re_n         (fl_re_n),
        .fl_ready        (fl_ready)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, "cle", fl_cle, 0);
        chk(req, "ale", fl_ale, 0);
        chk(req, "we_n", fl_we_n, 1);
        chk(req, "re_n", fl_re_n, 1);
        chk(req, "io", fl_io, 0);
        chk(req, "data_ready", host_data_ready, 0);
    endtask

    task automatic next_cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Full transaction with busy handshake and input disturbance (R2-R7, R9).
    task automatic run_txn(input vec_t v);
        logic [7:0] exp_io;
        host_addr   = v.addr;
        host_rd_req = 1'b1;
        host_seq    = 1'b0;
        next_cyc();
        host_rd_req = 1'b0;
        host_addr   = ~v.addr;        // R3: later address changes ignored
        host_seq    = 1'b1;           // R9: flag ignored outside idle
        for (int i = 1; i <= 14; i++) begin
            if (i <= 4) exp_io = 8'h00;
            else if (i <= 7) exp_io = v.addr[7:0];
            else if (i <= 10) exp_io = v.addr[15:8];
            else if (i <= 13) exp_io = {1'b0, v.addr[22:16]};
            else exp_io = 8'h00;
            chk(i <= 4 ? "R2" : "R3", "io", fl_io, exp_io);
            chk("R2", "cle", fl_cle, (i <= 3) ? 1 : 0);
            chk("R3", "ale", fl_ale, (i >= 5 && i <= 13) ? 1 : 0);
            chk(i <= 4 ? "R2" : "R3", "we_n", fl_we_n,
                (i == 1 || i == 2 || i == 5 || i == 6 || i == 8 || i == 9 ||
                 i == 11 || i == 12) ? 0 : 1);
            if (i < 14) next_cyc();
        end
        // R4: cycle 14 idle strobes, then stall while the device stays ready.
        chk("R4", "re_n", fl_re_n, 1);
        for (int k = 0; k < v.pre_busy; k++) begin
            next_cyc();
            chk("R4", "stall data_ready", host_data_ready, 0);
        end
        fl_ready = 1'b0;
        for (int k = 0; k < v.busy_len; k++) begin
            host_rd_req = (k == 0);   // R9: request pulse while busy ignored
            next_cyc();
            chk("R4", "busy data_ready", host_data_ready, 0);
            chk("R9", "busy re_n", fl_re_n, 1);
        end
        host_rd_req = 1'b0;
        host_seq    = 1'b0;
        fl_ready    = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            next_cyc();
            chk("R5", "data_ready timing", host_data_ready, (k == 5) ? 1 : 0);
            chk("R6", "re_n timing", fl_re_n, (k == 4 || k == 5) ? 0 : 1);
        end
        chk("R9", "idle cle after read", fl_cle, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        // R1: reset state.
        repeat (3) next_cyc();
        chk_idle("R1");
        rst_n = 1'b1;
        next_cyc();
        chk_idle("R9");

        // Vector table loop.
        for (int v = 0; v < N_VEC; v++) begin
            run_txn(VECS[v]);
        end

        // R8: sequential-access bypass.
        host_seq = 1'b1;
        host_rd_req = 1'b1;
        next_cyc();
        host_rd_req = 1'b0;
        host_seq = 1'b0;
        chk("R8", "cle", fl_cle, 0);
        chk("R8", "ale", fl_ale, 0);
        chk("R8", "we_n", fl_we_n, 1);
        chk("R8", "re_n c1", fl_re_n, 1);
        next_cyc();
        chk("R8", "re_n c2", fl_re_n, 0);
        chk("R8", "data_ready c2", host_data_ready, 0);
        next_cyc();
        chk("R8", "data_ready c3", host_data_ready, 1);
        chk("R7", "re_n under ready", fl_re_n, 0);
        next_cyc();
        chk("R7", "data_ready single", host_data_ready, 0);
        chk("R6", "re_n release", fl_re_n, 1);

        // R9: request low keeps idle.
        repeat (4) begin
            next_cyc();
            chk_idle("R9");
        end

        // R10: reset during the address phase.
        host_addr = 23'h3C3C3C;
        host_rd_req = 1'b1;
        next_cyc();
        host_rd_req = 1'b0;
        repeat (6) next_cyc();
        chk("R10", "ale before reset", fl_ale, 1);
        rst_n = 1'b0;
        next_cyc();
        chk_idle("R10");
        rst_n = 1'b1;
        next_cyc();
        chk_idle("R10");

        // R10: reset while the read strobe is low.
        host_seq = 1'b1;
        host_rd_req = 1'b1;
        next_cyc();
        host_rd_req = 1'b0;
        host_seq = 1'b0;
        next_cyc();
        chk("R10", "re_n low before reset", fl_re_n, 0);
        rst_n = 1'b0;
        next_cyc();
        chk("R10", "re_n after reset", fl_re_n, 1);
        chk("R10", "data_ready after reset", host_data_ready, 0);
        rst_n = 1'b1;
        repeat (3) begin
            next_cyc();
            chk_idle("R10");
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule